// File: doc/BRIEF.md
# Clustered Replicated Integer Register File

This block holds the physical integer registers of an out-of-order core as two complete copies, cluster 0 and cluster 1. Each copy serves one integer execution unit and one address/load-store unit. Each cluster has four read ports, two for each unit's operands, and two write ports for its own results. A cluster writes its own copy directly. Every such write is also captured into a one-entry transfer stage and lands in the other copy on the following clock edge. Each copy therefore takes only its own cluster's writes plus one delayed stream, rather than every write port of the core.

Each copy keeps a readiness bit per register. This bit says whether the value is visible in that copy. Issue logic queries these bits per cluster, so it can see that a consumer in the producer's cluster is ready one cycle earlier than one in the other cluster. When the rename logic hands out a register again, an allocation input clears that register's readiness in both copies. Physical register 31 is the hardwired zero register. It has no usable storage, always reads zero and is always ready.

Every port is a plain, unhandshaked path, and the block accepts every write enable in the cycle it is raised. A write enable therefore acts as a valid signal whose ready is permanently high, and there is no back-pressure. Reads are combinational, and read data is valid in the same cycle as the address. The rename logic must never let two local writes, or a local write and an arriving mirrored write, target the same entry in one cycle. If it does, the local write takes the entry and an assertion fires.

Top module: `clustered_regfile`

## Requirements
- R1: After reset, in both clusters, the readiness bits of registers 0 to 31 read 1 and those of registers 32 to 79 read 0.
- R2: Register 31, in both clusters and on every read port, reads as 64'h0. This holds in the cycle of a write to it and afterwards. Its readiness always reads 1, even after a write to it or an allocation of it.
- R3: A read in cluster c of a register that cluster c writes in the same cycle returns the new data combinationally. From the next cycle onward, the read returns the same data from storage.
- R4: A write made in one cluster at clock edge T is visible in the other cluster's copy only after edge T+1. Reads there in the cycle between T and T+1 return the previous value. This holds in both directions.
- R5: The writing cluster's readiness bit for a register becomes 1 after the write's edge T. The other cluster's readiness bit for that register becomes 1 one cycle later, after edge T+1.
- R6: An allocation of register k clears k's readiness in both clusters after the next edge. Until that edge, both clusters still report k as ready. The stored data of k is unchanged.
- R7: All four read ports of a cluster operate independently. Both write ports of both clusters can write four distinct registers in the same cycle. All four values then appear in both copies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 4 | Write enable; bit c*2+p is write port p of cluster c |
| wr_addr | input | 28 | Write register index, 7 bits per write port, same ordering as wr_en |
| wr_data | input | 256 | Write data, 64 bits per write port |
| rd_addr | input | 56 | Read register index, 7 bits per read port; port r of cluster c is slot c*4+r |
| rd_data | output | 512 | Read data, 64 bits per read port, same slot ordering |
| qry_addr | input | 28 | Readiness query index, 7 bits per query; query q of cluster c is slot c*2+q |
| qry_rdy | output | 4 | Readiness bit of the queried register in that cluster's copy |
| alloc_en | input | 1 | Clear the readiness of alloc_addr in both clusters |
| alloc_addr | input | 7 | Register being reallocated |

## Verification
A register first receives a known old value from cluster 1. It is then overwritten from cluster 0, and both clusters are read and queried in each of the following three cycles. This separates the same-cycle bypass, the local storage path and the one-cycle-late mirrored path, and it shows that the readiness bits follow the same one-cycle skew. In a separate pattern, all four write ports fire at once into distinct registers. The eight read ports then read them back in crossed orders, which exposes any swapped port slicing or a lost mirrored write. Further patterns exercise the zero register and allocation. Allocation must clear readiness while keeping the data, and the zero register must ignore both writes and allocation.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int DEF_NREG  = 80;  // physical entries per copy
  localparam int DEF_XLEN  = 64;  // register width
  localparam int DEF_NRD   = 4;   // read ports per cluster
  localparam int DEF_NWR   = 2;   // local write ports per cluster
  localparam int DEF_NQRY  = 2;   // readiness queries per cluster
  localparam int DEF_ZREG  = 31;  // hardwired zero register
  localparam int DEF_NINIT = 32;  // registers ready at reset (initial mapping)
  localparam int NUM_CLUSTERS = 2;
endpackage

// File: rtl/rf_xfer.sv
// One-cycle transfer stage carrying a cluster's writes to the other copy.
module rf_xfer #(
  parameter int NW = 2,
  parameter int AW = 7,
  parameter int DW = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NW-1:0]    in_en,
  input  logic [NW*AW-1:0] in_addr,
  input  logic [NW*DW-1:0] in_data,
  output logic [NW-1:0]    out_en,
  output logic [NW*AW-1:0] out_addr,
  output logic [NW*DW-1:0] out_data
);
  always_ff @(posedge clk) begin
    if (rst) out_en <= '0;
    else     out_en <= in_en;
  end

  for (genvar i = 0; i < NW; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (in_en[i]) begin
        out_addr[i*AW +: AW] <= in_addr[i*AW +: AW];
        out_data[i*DW +: DW] <= in_data[i*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/rf_copy.sv
// One cluster's copy: storage, readiness bits, local bypass reads.
module rf_copy #(
  parameter int NREG  = 80,
  parameter int DW    = 64,
  parameter int NLW   = 2,
  parameter int NRW   = 2,
  parameter int NRD   = 4,
  parameter int ZREG  = 31,
  parameter int NINIT = 32,
  localparam int AW = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NLW-1:0]    lw_en,
  input  logic [NLW*AW-1:0] lw_addr,
  input  logic [NLW*DW-1:0] lw_data,
  input  logic [NRW-1:0]    rw_en,
  input  logic [NRW*AW-1:0] rw_addr,
  input  logic [NRW*DW-1:0] rw_data,
  input  logic [NRD*AW-1:0] rd_addr,
  output logic [NRD*DW-1:0] rd_data,
  input  logic              clr_en,
  input  logic [AW-1:0]     clr_addr,
  output logic [NREG-1:0]   vld_vec
);
  localparam logic [AW-1:0] ZA = AW'(ZREG);

  logic [DW-1:0]   mem [NREG];
  logic [NREG-1:0] vld_q;

  // Mirrored writes first, local writes last: on a clash the local one wins.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NRW; i++)
      if (rw_en[i] && rw_addr[i*AW +: AW] != ZA)
        mem[rw_addr[i*AW +: AW]] <= rw_data[i*DW +: DW];
    for (int i = 0; i < NLW; i++)
      if (lw_en[i] && lw_addr[i*AW +: AW] != ZA)
        mem[lw_addr[i*AW +: AW]] <= lw_data[i*DW +: DW];
  end

  // Readiness: clear on allocation, set by any write landing in this copy.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++)
        vld_q[k] <= (k < NINIT) || (k == ZREG);
    end else begin
      if (clr_en) vld_q[clr_addr] <= 1'b0;
      for (int i = 0; i < NRW; i++)
        if (rw_en[i]) vld_q[rw_addr[i*AW +: AW]] <= 1'b1;
      for (int i = 0; i < NLW; i++)
        if (lw_en[i]) vld_q[lw_addr[i*AW +: AW]] <= 1'b1;
      vld_q[ZA] <= 1'b1;
    end
  end

  assign vld_vec = vld_q;

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    logic [AW-1:0] ra;
    logic [DW-1:0] rv;
    assign ra = rd_addr[r*AW +: AW];
    always_comb begin
      rv = mem[ra];
      for (int i = 0; i < NLW; i++)
        if (lw_en[i] && lw_addr[i*AW +: AW] == ra) rv = lw_data[i*DW +: DW];
      if (ra == ZA) rv = '0;
    end
    assign rd_data[r*DW +: DW] = rv;

    AST_ZERO_READ: assert property (@(posedge clk) disable iff (rst)
      (ra == ZA) |-> (rd_data[r*DW +: DW] == '0)); // R2
  end

  for (genvar i = 0; i < NLW; i++) begin : g_chk_l
    AST_LOCAL_SEEN: assert property (@(posedge clk) disable iff (rst)
      (lw_en[i] && lw_addr[i*AW +: AW] != ZA) |=> vld_q[$past(lw_addr[i*AW +: AW])]); // R5
    for (genvar j = 0; j < NRW; j++) begin : g_chk_r
      AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        (lw_en[i] && rw_en[j] && lw_addr[i*AW +: AW] != ZA)
          |-> (lw_addr[i*AW +: AW] != rw_addr[j*AW +: AW])); // R4
    end
    for (genvar j = i + 1; j < NLW; j++) begin : g_chk_p
      AST_LOCAL_DISTINCT: assert property (@(posedge clk) disable iff (rst)
        (lw_en[i] && lw_en[j] && lw_addr[i*AW +: AW] != ZA)
          |-> (lw_addr[i*AW +: AW] != lw_addr[j*AW +: AW])); // R7
    end
  end
endmodule

// File: rtl/clustered_regfile.sv
module clustered_regfile
  import rf_pkg::*;
#(
  parameter int NREG  = DEF_NREG,
  parameter int DW    = DEF_XLEN,
  parameter int NRD   = DEF_NRD,
  parameter int NWR   = DEF_NWR,
  parameter int NQRY  = DEF_NQRY,
  parameter int ZREG  = DEF_ZREG,
  parameter int NINIT = DEF_NINIT,
  localparam int NCL = NUM_CLUSTERS,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCL*NWR-1:0]    wr_en,
  input  logic [NCL*NWR*AW-1:0] wr_addr,
  input  logic [NCL*NWR*DW-1:0] wr_data,
  input  logic [NCL*NRD*AW-1:0] rd_addr,
  output logic [NCL*NRD*DW-1:0] rd_data,
  input  logic [NCL*NQRY*AW-1:0] qry_addr,
  output logic [NCL*NQRY-1:0]   qry_rdy,
  input  logic                  alloc_en,
  input  logic [AW-1:0]         alloc_addr
);
  localparam logic [AW-1:0] ZA = AW'(ZREG);

  logic [NREG-1:0]   vld_all [NCL];
  logic [NWR-1:0]    x_en    [NCL];
  logic [NWR*AW-1:0] x_addr  [NCL];
  logic [NWR*DW-1:0] x_data  [NCL];

  for (genvar c = 0; c < NCL; c++) begin : g_cl
    rf_xfer #(.NW(NWR), .AW(AW), .DW(DW)) u_xfer (
      .clk      (clk),
      .rst      (rst),
      .in_en    (wr_en  [c*NWR +: NWR]),
      .in_addr  (wr_addr[c*NWR*AW +: NWR*AW]),
      .in_data  (wr_data[c*NWR*DW +: NWR*DW]),
      .out_en   (x_en[c]),
      .out_addr (x_addr[c]),
      .out_data (x_data[c])
    );

    rf_copy #(
      .NREG(NREG), .DW(DW), .NLW(NWR), .NRW(NWR), .NRD(NRD),
      .ZREG(ZREG), .NINIT(NINIT)
    ) u_copy (
      .clk      (clk),
      .rst      (rst),
      .lw_en    (wr_en  [c*NWR +: NWR]),
      .lw_addr  (wr_addr[c*NWR*AW +: NWR*AW]),
      .lw_data  (wr_data[c*NWR*DW +: NWR*DW]),
      .rw_en    (x_en  [NCL-1-c]),
      .rw_addr  (x_addr[NCL-1-c]),
      .rw_data  (x_data[NCL-1-c]),
      .rd_addr  (rd_addr[c*NRD*AW +: NRD*AW]),
      .rd_data  (rd_data[c*NRD*DW +: NRD*DW]),
      .clr_en   (alloc_en),
      .clr_addr (alloc_addr),
      .vld_vec  (vld_all[c])
    );

    for (genvar q = 0; q < NQRY; q++) begin : g_q
      assign qry_rdy[c*NQRY+q] = vld_all[c][qry_addr[(c*NQRY+q)*AW +: AW]];
    end

    for (genvar p = 0; p < NWR; p++) begin : g_chk
      AST_MIRROR_LAG: assert property (@(posedge clk) disable iff (rst)
        (wr_en[c*NWR+p] && wr_addr[(c*NWR+p)*AW +: AW] != ZA)
          |=> ##1 vld_all[NCL-1-c][$past(wr_addr[(c*NWR+p)*AW +: AW], 2)]); // R4
    end
  end
endmodule

// File: tb/tb_clustered_regfile.sv
module tb_clustered_regfile;
  localparam int NRD = 4, NWR = 2, NQ = 2, AW = 7, DW = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*NWR-1:0]    wr_en;
  logic [2*NWR*AW-1:0] wr_addr;
  logic [2*NWR*DW-1:0] wr_data;
  logic [2*NRD*AW-1:0] rd_addr;
  logic [2*NRD*DW-1:0] rd_data;
  logic [2*NQ*AW-1:0]  qry_addr;
  logic [2*NQ-1:0]     qry_rdy;
  logic                alloc_en;
  logic [AW-1:0]       alloc_addr;

  always #4 clk = ~clk;

  clustered_regfile dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .qry_addr(qry_addr), .qry_rdy(qry_rdy),
    .alloc_en(alloc_en), .alloc_addr(alloc_addr)
  );

  typedef struct {
    bit          is_q;
    int          cl;
    int          idx;
    logic [63:0] val;
    string       tag;
  } exp_t;

  exp_t sbq[$];
  exp_t e;
  logic [63:0] act;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [63:0] OLD = 64'h1111_2222_3333_4444;
  localparam logic [63:0] D1  = 64'hA5A5_5A5A_0F0F_F0F0;
  localparam logic [63:0] D2  = 64'h0000_0000_0000_0D02;
  localparam logic [63:0] D3  = 64'hDEAD_BEEF_0000_0D03;
  localparam logic [63:0] D4  = 64'h8000_0000_0000_0D04;
  localparam logic [63:0] D5  = 64'h7FFF_FFFF_FFFF_0D05;
  localparam logic [63:0] D6  = 64'hCAFE_F00D_1234_5678;

  task automatic clear_in();
    wr_en = '0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; qry_addr = '0; alloc_en = 1'b0; alloc_addr = '0;
  endtask

  task automatic tick();
    @(negedge clk);
    clear_in();
  endtask

  task automatic drv_wr(int cl, int p, int a, logic [63:0] d);
    wr_en[cl*NWR+p] = 1'b1;
    wr_addr[(cl*NWR+p)*AW +: AW] = AW'(a);
    wr_data[(cl*NWR+p)*DW +: DW] = d;
  endtask

  task automatic drv_alloc(int a);
    alloc_en = 1'b1;
    alloc_addr = AW'(a);
  endtask

  // driver: set a read address and push its expected data
  task automatic exp_rd(int cl, int r, int a, logic [63:0] v, string tag);
    exp_t x;
    rd_addr[(cl*NRD+r)*AW +: AW] = AW'(a);
    x.is_q = 0; x.cl = cl; x.idx = r; x.val = v; x.tag = tag;
    sbq.push_back(x);
  endtask

  task automatic exp_q(int cl, int q, int a, bit v, string tag);
    exp_t x;
    qry_addr[(cl*NQ+q)*AW +: AW] = AW'(a);
    x.is_q = 1; x.cl = cl; x.idx = q; x.val = {63'd0, v}; x.tag = tag;
    sbq.push_back(x);
  endtask

  // monitor: compare mid-cycle, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sbq.size() > 0) begin
        e = sbq.pop_front();
        if (e.is_q) act = {63'd0, qry_rdy[e.cl*NQ+e.idx]};
        else        act = rd_data[(e.cl*NRD+e.idx)*DW +: DW];
        checks++;
        if (act !== e.val) begin
          errors++;
          $display("FAIL %s cl%0d %s%0d actual=%h expected=%h",
                   e.tag, e.cl, e.is_q ? "qry" : "rd", e.idx, act, e.val);
        end
      end
    end
  end

  initial begin
    repeat (3000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all) actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // C0: reset state
    exp_q(0, 0, 5, 1'b1, "R1");
    exp_q(0, 1, 79, 1'b0, "R1");
    exp_q(1, 0, 0, 1'b1, "R1");
    exp_q(1, 1, 40, 1'b0, "R1");
    exp_rd(0, 0, 31, 64'd0, "R2");
    tick();
    // C1: preload 40 from cluster 1, bypass in cluster 1
    drv_wr(1, 1, 40, OLD);
    exp_rd(1, 3, 40, OLD, "R3");
    tick();
    // C2: local ready, remote not yet
    exp_q(1, 0, 40, 1'b1, "R5");
    exp_q(0, 0, 40, 1'b0, "R5");
    exp_rd(1, 0, 40, OLD, "R3");
    tick();
    // C3: remote now visible; allocate 40 (still ready this cycle)
    exp_q(0, 0, 40, 1'b1, "R5");
    exp_rd(0, 1, 40, OLD, "R4");
    exp_q(1, 1, 40, 1'b1, "R6");
    drv_alloc(40);
    tick();
    // C4: readiness cleared in both, data kept
    exp_q(0, 0, 40, 1'b0, "R6");
    exp_q(1, 0, 40, 1'b0, "R6");
    exp_rd(0, 0, 40, OLD, "R6");
    exp_rd(1, 1, 40, OLD, "R6");
    tick();
    // C5: overwrite 40 from cluster 0
    drv_wr(0, 0, 40, D1);
    exp_rd(0, 2, 40, D1, "R3");
    exp_rd(1, 2, 40, OLD, "R4");
    exp_q(0, 0, 40, 1'b0, "R5");
    tick();
    // C6: local storage new, remote still old
    exp_rd(0, 0, 40, D1, "R3");
    exp_rd(1, 0, 40, OLD, "R4");
    exp_q(0, 1, 40, 1'b1, "R5");
    exp_q(1, 1, 40, 1'b0, "R5");
    tick();
    // C7: remote caught up; write to the zero register
    exp_rd(1, 3, 40, D1, "R4");
    exp_q(1, 0, 40, 1'b1, "R5");
    drv_wr(0, 1, 31, 64'hFFFF_FFFF_FFFF_FFFF);
    exp_rd(0, 1, 31, 64'd0, "R2");
    tick();
    // C8
    exp_rd(0, 2, 31, 64'd0, "R2");
    exp_q(0, 0, 31, 1'b1, "R2");
    drv_alloc(31);
    tick();
    // C9: zero reg after mirror and alloc; four writes at once
    exp_rd(1, 1, 31, 64'd0, "R2");
    exp_q(1, 1, 31, 1'b1, "R2");
    exp_q(0, 1, 31, 1'b1, "R2");
    drv_wr(0, 0, 50, D2);
    drv_wr(0, 1, 51, D3);
    drv_wr(1, 0, 60, D4);
    drv_wr(1, 1, 61, D5);
    exp_rd(0, 0, 50, D2, "R7");
    exp_rd(0, 3, 51, D3, "R7");
    exp_rd(1, 0, 60, D4, "R7");
    exp_rd(1, 2, 61, D5, "R7");
    tick();
    // C10
    exp_rd(0, 0, 50, D2, "R3");
    exp_q(1, 0, 50, 1'b0, "R5");
    tick();
    // C11: every port, crossed order, both copies
    exp_rd(0, 0, 50, D2, "R7");
    exp_rd(0, 1, 51, D3, "R7");
    exp_rd(0, 2, 60, D4, "R7");
    exp_rd(0, 3, 61, D5, "R7");
    exp_rd(1, 0, 61, D5, "R7");
    exp_rd(1, 1, 60, D4, "R7");
    exp_rd(1, 2, 51, D3, "R7");
    exp_rd(1, 3, 50, D2, "R7");
    tick();
    // C12: reverse direction mirror
    drv_wr(1, 0, 50, D6);
    exp_rd(0, 0, 50, D2, "R4");
    tick();
    // C13
    exp_rd(0, 0, 50, D2, "R4");
    tick();
    // C14
    exp_rd(0, 0, 50, D6, "R4");
    exp_q(0, 0, 50, 1'b1, "R5");
    tick();
    #3;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule